// File: doc/BRIEF.md
# Audio master clock divider

This block turns a stream of input clock-enable pulses into the enable for the internal codec clock. One of three pulse sources is chosen: the master clock, the bit clock or an auxiliary pin. The source pulses have already been brought into the system clock domain, so each one is a single-cycle high on its input. The output rate is the chosen input rate times 2/Q, with Q from 2 to 17. This gives a division from 1 to 8.5 in half steps. The codec clock runs at 256 times the reference sample rate, so the reference rate works out to the input rate divided by 128·Q.

A phase accumulator does the division. It adds 2 on each selected input pulse. When the sum reaches Q or more, it subtracts Q and emits one output pulse.

The block also takes a flag that says the downstream sample-rate ratio is a half-integer. With that flag set, an odd Q is illegal. An unused select code is illegal as well.

A small controller has two states:

- ST_HOLD: the accumulator is cleared, outputs are muted and the live configuration is copied every cycle.
- ST_RUN: pulses are divided.

Transitions:

- HOLD to RUN is taken when the live configuration is legal.
- RUN to HOLD is taken as soon as it becomes illegal.
- Each state loops on itself otherwise.

While in ST_RUN, a legal change of source or Q is adopted only on a cycle where the accumulator wraps. This means no shortened or stretched period is ever produced.

Top module: `mclk_frac_div`

## Requirements
- R1: `src_sel` picks the pulse source: 0 selects `mclk_tick`, 1 selects `bclk_tick`, 2 selects `aux_tick`. Pulses on the other two inputs have no effect on the output.
- R2: `src_sel` = 3 is illegal. The cycle after it is presented, `cfg_err` is 1.
- R3: The divisor is Q = `q_code` + 2. Counted from a cleared accumulator, the i-th selected pulse (i from 1) produces an output pulse exactly when floor(2i/Q) > floor(2(i-1)/Q). As a result, 2·Q·K selected pulses give exactly 4·K output pulses, for every Q from 2 to 17.
- R4: `codec_tick` is high for one cycle, in the cycle after the selected input pulse that causes it. At most one output pulse follows each input pulse. With Q = 2, every selected pulse, including pulses on consecutive cycles, produces one output pulse.
- R5: With `half_ratio` = 1 and `q_code` odd (Q odd), `cfg_err` is 1 the next cycle and no output pulses are produced. With `half_ratio` = 1 and Q even, division is normal.
- R6: `cfg_err` follows the legality of the inputs with one cycle of delay. Any illegal configuration sends the block to ST_HOLD and clears the accumulator. After a legal configuration returns, counting restarts from zero.
- R7: In ST_RUN, a legal change of `src_sel` or `q_code` takes effect only after the next output pulse. That pulse is still produced with the old source and old Q.
- R8: While `rst` (synchronous, active high) is 1, `codec_tick` and `cfg_err` are 0. The accumulator is cleared and the block enters ST_HOLD. After release, counting starts from zero.
- R9: A selected pulse is counted only in ST_RUN. Entering ST_RUN takes one cycle with a legal configuration in ST_HOLD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mclk_tick | input | 1 | Master clock enable pulse (source 0) |
| bclk_tick | input | 1 | Bit clock enable pulse (source 1) |
| aux_tick | input | 1 | Auxiliary pin enable pulse (source 2) |
| src_sel | input | 2 | Source select code |
| q_code | input | QCODE_W | Divisor code, Q = q_code + 2 |
| half_ratio | input | 1 | Downstream ratio is a half-integer |
| codec_tick | output | 1 | Codec clock enable pulse |
| cfg_err | output | 1 | Configuration illegal |

## Verification
The hardest case to reach from the ports is a configuration change landing in the middle of a division period. Such a change must be held back until the next wrap, and the old Q still governs that one pulse. The stimulus first drops into ST_HOLD through an illegal select code, which clears the accumulator and loads a known Q. It then applies a few pulses to put the accumulator at a known partial sum, and only then changes `q_code` or `src_sel`. The expected pulse pattern after the change tells an immediate switch apart from a deferred one. The full Q sweep also enters every Q through ST_HOLD, so each count window starts from a cleared accumulator.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;
    typedef enum logic [1:0] {
        SRC_MCLK = 2'd0,
        SRC_BCLK = 2'd1,
        SRC_AUX  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } mode_e;

    localparam int unsigned ACC_STEP = 2;
    localparam int unsigned SEL_W    = 2;
endpackage

// File: rtl/src_pick.sv
module src_pick #(
    parameter int unsigned NSRC  = 3,
    parameter int unsigned SEL_W = 2
) (
    input  logic [NSRC-1:0]  ticks,
    input  logic [SEL_W-1:0] sel,
    output logic             pick
);
    logic [NSRC-1:0] hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = ticks[i] && (sel == SEL_W'(i));
    end

    assign pick = |hit;
endmodule

// File: rtl/cfg_fsm.sv
module cfg_fsm
    import mdiv_pkg::*;
#(
    parameter int unsigned QCODE_W = 4,
    parameter int unsigned NSRC    = 3,
    localparam int unsigned QV_W   = QCODE_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [QCODE_W-1:0] q_code,
    input  logic               half_ratio,
    input  logic               wrap,
    output logic               run,
    output logic               legal,
    output logic [SEL_W-1:0]   act_sel,
    output logic [QV_W-1:0]    act_q,
    output logic               cfg_err
);
    mode_e state, state_nxt;
    logic  load;

    assign legal = (src_sel < SEL_W'(NSRC)) && !(half_ratio && q_code[0]);
    assign run   = (state == ST_RUN);
    assign load  = (state == ST_HOLD) || wrap;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLD: state_nxt = legal ? ST_RUN : ST_HOLD;
            ST_RUN:  state_nxt = legal ? ST_RUN : ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_HOLD;
        else     state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_sel <= src_sel;
            act_q   <= {1'b0, q_code} + QV_W'(2);
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= !legal;
            if (load) begin
                act_sel <= src_sel;
                act_q   <= {1'b0, q_code} + QV_W'(2);
            end
        end
    end

    // R7
    cfg_latch_chk: assert property (@(posedge clk) disable iff (rst)
        $past(run && !wrap) |-> ($stable(act_q) && $stable(act_sel)));

    // R9
    run_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> $past(legal));
endmodule

// File: rtl/frac_accum.sv
module frac_accum #(
    parameter int unsigned QV_W  = 5,
    parameter int unsigned ACC_W = 5,
    parameter int unsigned STEP  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [QV_W-1:0]  q_val,
    output logic             wrap,
    output logic             pulse,
    output logic [ACC_W-1:0] acc
);
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] q_ext;

    assign q_ext = ACC_W'(q_val);
    assign sum   = acc + ACC_W'(STEP);
    assign wrap  = adv && (sum >= q_ext);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= wrap;
            if (adv) acc <= wrap ? (sum - q_ext) : sum;
        end
    end

    // R3
    acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        acc < q_ext);

    // R4
    pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(adv));
endmodule

// File: rtl/mclk_frac_div.sv
module mclk_frac_div
    import mdiv_pkg::*;
#(
    parameter int unsigned QCODE_W = 4,
    parameter int unsigned NSRC    = 3,
    localparam int unsigned QV_W   = QCODE_W + 1,
    localparam int unsigned ACC_W  = $clog2((2 ** QCODE_W) + ACC_STEP + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mclk_tick,
    input  logic               bclk_tick,
    input  logic               aux_tick,
    input  logic [1:0]         src_sel,
    input  logic [QCODE_W-1:0] q_code,
    input  logic               half_ratio,
    output logic               codec_tick,
    output logic               cfg_err
);
    logic [NSRC-1:0]  ticks;
    logic             pick, run, legal, wrap, adv, clr;
    logic [SEL_W-1:0] act_sel;
    logic [QV_W-1:0]  act_q;
    logic [ACC_W-1:0] acc;

    assign ticks = NSRC'({aux_tick, bclk_tick, mclk_tick});
    assign adv   = pick && run && legal;
    assign clr   = !(run && legal);

    src_pick #(.NSRC(NSRC), .SEL_W(SEL_W)) u_pick (
        .ticks (ticks),
        .sel   (act_sel),
        .pick  (pick)
    );

    cfg_fsm #(.QCODE_W(QCODE_W), .NSRC(NSRC)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .src_sel    (src_sel),
        .q_code     (q_code),
        .half_ratio (half_ratio),
        .wrap       (wrap),
        .run        (run),
        .legal      (legal),
        .act_sel    (act_sel),
        .act_q      (act_q),
        .cfg_err    (cfg_err)
    );

    frac_accum #(.QV_W(QV_W), .ACC_W(ACC_W), .STEP(ACC_STEP)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .adv   (adv),
        .q_val (act_q),
        .wrap  (wrap),
        .pulse (codec_tick),
        .acc   (acc)
    );

    // R5
    err_mute_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !codec_tick);

    // R8
    rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!codec_tick && !cfg_err));

    // R6
    hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> (acc == '0));
endmodule

// File: tb/tb_mclk_frac_div.sv
module tb_mclk_frac_div;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mclk_tick = 1'b0, bclk_tick = 1'b0, aux_tick = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [3:0] q_code = 4'd0;
    logic       half_ratio = 1'b0;
    logic       codec_tick, cfg_err;

    int    tests = 0;
    int    fails = 0;
    int    pulse_cnt = 0;
    bit    tick_drv = 1'b0;
    bit    cap = 1'b0;
    bit    exp_q[$];
    string tag_q[$];

    mclk_frac_div dut (
        .clk(clk), .rst(rst), .mclk_tick(mclk_tick), .bclk_tick(bclk_tick),
        .aux_tick(aux_tick), .src_sel(src_sel), .q_code(q_code),
        .half_ratio(half_ratio), .codec_tick(codec_tick), .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cap <= tick_drv;

    always @(negedge clk) begin
        if (codec_tick) pulse_cnt++;
        if (cap) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard empty: codec_tick=%0b expected none", codec_tick);
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (codec_tick !== e) begin
                    fails++;
                    $display("FAIL %s: codec_tick=%0b expected %0b", t, codec_tick, e);
                end
            end
        end else if (codec_tick) begin
            tests++;
            fails++;
            $display("FAIL R4: codec_tick=1 expected 0 (no input pulse)");
        end
    end

    task automatic check(input string t, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_in(input logic m, input logic b, input logic a,
                            input bit e, input string t);
        @(posedge clk); #2;
        mclk_tick = m; bclk_tick = b; aux_tick = a;
        tick_drv = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #2;
        mclk_tick = 1'b0; bclk_tick = 1'b0; aux_tick = 1'b0;
        tick_drv = 1'b0;
    endtask

    task automatic sel_pulse(input int s, input bit e, input string t);
        pulse_in(s == 0, s == 1, s == 2, e, t);
    endtask

    task automatic burst(input int n, input string t);
        @(posedge clk); #2;
        mclk_tick = 1'b1; tick_drv = 1'b1;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(1'b1); tag_q.push_back(t);
            @(posedge clk); #2;
        end
        mclk_tick = 1'b0; tick_drv = 1'b0;
    endtask

    task automatic via_hold(input int s, input int c, input bit h);
        src_sel = 2'd3;
        idle(2);
        check("R2 cfg_err on select 3", int'(cfg_err), 1);
        src_sel = 2'(s); q_code = 4'(c); half_ratio = h;
        idle(2);
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    initial begin
        #(20 * 150000);
        tests++; fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(3);
        check("R8 codec_tick in reset", int'(codec_tick), 0);
        check("R8 cfg_err in reset", int'(cfg_err), 0);
        rst = 1'b0;
        idle(2);

        // R3 sweep over every Q, K = 2, source rotated (R1)
        for (int c = 0; c < 16; c++) begin
            automatic int q = c + 2;
            automatic int s = c % 3;
            automatic int base;
            via_hold(s, c, 1'b0);
            check("R6 cfg_err clear", int'(cfg_err), 0);
            settle();
            base = pulse_cnt;
            for (int i = 1; i <= 4 * q; i++) begin
                automatic bit e = ((2 * i) / q) != ((2 * (i - 1)) / q);
                sel_pulse(s, e, "R3");
                if (i == 1) sel_pulse((s + 1) % 3, 1'b0, "R1 other source ignored");
            end
            settle();
            check("R3 pulses per 2QK window", pulse_cnt - base, 8);
        end

        // R5 half ratio with odd Q
        via_hold(0, 1, 1'b1);
        check("R5 cfg_err odd Q", int'(cfg_err), 1);
        for (int i = 0; i < 3; i++) sel_pulse(0, 1'b0, "R5 muted");
        half_ratio = 1'b1; q_code = 4'd2; src_sel = 2'd0;
        idle(2);
        check("R5 cfg_err even Q", int'(cfg_err), 0);
        sel_pulse(0, 1'b0, "R5"); sel_pulse(0, 1'b1, "R5");
        sel_pulse(0, 1'b0, "R5"); sel_pulse(0, 1'b1, "R5");

        // R6 restart from zero after error
        via_hold(0, 4, 1'b0);
        sel_pulse(0, 1'b0, "R6"); sel_pulse(0, 1'b0, "R6");
        via_hold(0, 4, 1'b0);
        sel_pulse(0, 1'b0, "R6 restart"); sel_pulse(0, 1'b0, "R6 restart");
        sel_pulse(0, 1'b1, "R6 restart");

        // R7 Q change deferred to wrap
        via_hold(0, 0, 1'b0);
        sel_pulse(0, 1'b1, "R7");
        q_code = 4'd4;
        idle(1);
        sel_pulse(0, 1'b1, "R7 old Q at wrap");
        sel_pulse(0, 1'b0, "R7 new Q"); sel_pulse(0, 1'b0, "R7 new Q");
        sel_pulse(0, 1'b1, "R7 new Q");

        // R7 source change deferred to wrap
        via_hold(0, 0, 1'b0);
        src_sel = 2'd1;
        idle(1);
        sel_pulse(1, 1'b0, "R7 new source not yet");
        sel_pulse(0, 1'b1, "R7 old source wraps");
        sel_pulse(1, 1'b1, "R7 new source");
        sel_pulse(0, 1'b0, "R7 old source dropped");

        // R4 consecutive pulses at Q = 2
        via_hold(0, 0, 1'b0);
        burst(4, "R4 back-to-back");

        // R8 mid-run reset
        via_hold(0, 4, 1'b0);
        sel_pulse(0, 1'b0, "R8"); sel_pulse(0, 1'b0, "R8");
        rst = 1'b1;
        idle(2);
        check("R8 codec_tick in reset", int'(codec_tick), 0);
        rst = 1'b0;
        idle(2);
        check("R9 cfg_err after release", int'(cfg_err), 0);
        sel_pulse(0, 1'b0, "R8 from zero"); sel_pulse(0, 1'b0, "R8 from zero");
        sel_pulse(0, 1'b1, "R8 from zero");

        // R9 pulse in first HOLD cycle is not counted
        src_sel = 2'd3;
        idle(2);
        src_sel = 2'd0; q_code = 4'd0;
        mclk_tick = 1'b1; tick_drv = 1'b1;
        exp_q.push_back(1'b0); tag_q.push_back("R9 pulse in HOLD");
        idle(1);
        mclk_tick = 1'b0; tick_drv = 1'b0;
        idle(1);
        sel_pulse(0, 1'b1, "R9 pulse in RUN");

        idle(3);
        check("R4 scoreboard drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule